// File: doc/BRIEF.md
# USB Repeater L1 Sleep Controller

This block is the control state machine of a two-port USB 2.0 repeater for the link-power-management L1 (sleep) state. Line-state decoders on both sides of the repeater supply the decoded bus state: single-ended zero, J or K. A link layer supplies the operating speed and a one-cycle pulse whenever it detects a request to enter L1. The controller accepts the request only while the bus is idle. It saves the speed, takes the repeater into its low-power condition within a bounded number of cycles, and turns off the high-speed circuits if the link was running at high speed.

While asleep, a K from either port starts the wake-up. The controller locks the repeat direction to the port that showed K first and drives a repeat strobe toward the opposite port. It then watches the upstream side for the end of resume. For low and full speed, this is a qualified run of single-ended zero followed by J. For high speed, it is the host's return to high-speed idle. On exit it reports the restored idle state and the saved speed.

Line-state encoding on `up_line` and `dn_line` is 2'b00 single-ended zero, 2'b01 J, 2'b10 K and 2'b11 invalid. Speed encoding on `speed_in` and `idle_speed` is 2'b00 low, 2'b01 full and 2'b10 high.

Top module: `l1_sleep_ctrl`

## Requirements
- R1: During and after reset the block is idle: `idle_valid`=1, `low_power`=0, both repeat strobes are 0, and `idle_speed` equals `speed_in`. While idle, `hs_enable` is 1 exactly when `speed_in` is 2'b10, one clock edge after the speed is sampled.
- R2: A request pulse is taken only when the upstream line shows the idle state for the current speed: J (2'b01) for low or full speed, and single-ended zero (2'b00) for high speed. Any other request leaves `idle_valid`=1 and `low_power`=0.
- R3: On the edge that samples an accepted request, `idle_valid` falls. `low_power` rises exactly ENTER_CYCLES edges later, and ENTER_CYCLES must not exceed DEADLINE_CYCLES, the cycle count of the 50 µs entry limit.
- R4: For a high-speed entry, `hs_enable` falls on the edge that samples the request. It stays 0 through sleep and resume.
- R5: For a low- or full-speed entry, `hs_enable` stays 0 and `idle_valid` stays 0 for the whole sleep.
- R6: In sleep, an upstream K (2'b10) starts host resume. From the next edge, `rep_k_to_dn` follows the upstream K with one cycle of latency. `rep_k_to_up` stays 0 even if the downstream port also shows K.
- R7: In sleep, a downstream K alone starts remote wake. `rep_k_to_up` follows the downstream K and `rep_k_to_dn` stays 0 even while upstream shows K. If both ports show K in the same cycle, the upstream side wins. The two strobes are never high together.
- R8: For low or full speed, once the host has shown K, SE0_CYCLES consecutive upstream single-ended-zero samples end resume. The edge that then samples upstream J sets `idle_valid`=1 and `low_power`=0.
- R9: An upstream single-ended zero shorter than SE0_CYCLES samples during low- or full-speed resume is ignored. The block stays asleep and K repetition resumes.
- R10: For high speed, the first upstream single-ended zero after the host has shown K ends resume. Upstream single-ended zero before any host K does not. On the following edge the block is idle with `hs_enable`=1.
- R11: After every exit, `idle_speed` reports the speed saved at entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| up_line | input | 2 | Decoded upstream line state |
| dn_line | input | 2 | Decoded downstream line state |
| speed_in | input | 2 | Current operating speed |
| l1_req | input | 1 | One-cycle L1 entry request pulse |
| low_power | output | 1 | Repeater is in its low-power sleep condition |
| hs_enable | output | 1 | Enable for the high-speed circuits |
| rep_k_to_up | output | 1 | Repeat K onto the upstream port |
| rep_k_to_dn | output | 1 | Repeat K onto the downstream port |
| idle_valid | output | 1 | Bus is in a normal idle state |
| idle_speed | output | 2 | Speed of the reported idle state |

## Verification
The bench sweeps the length of the upstream single-ended-zero run from zero up to one sample short of qualification. A design that counted one short, or that failed to clear its count when K returned, would leave sleep on a glitch. The bench feeds K back onto the port that started the wake-up and fires K on both ports in the same cycle; a design without a locked direction would drive both strobes and loop the signal back. In high-speed remote wake, the upstream line already sits at single-ended zero before the host answers, so a design that did not wait for the host's K would exit immediately. Requests on a non-idle bus and the exact entry latency are checked for each speed.

// File: rtl/l1_pkg.sv
package l1_pkg;

  typedef enum logic [1:0] {
    LINE_SE0 = 2'b00,
    LINE_J   = 2'b01,
    LINE_K   = 2'b10,
    LINE_SE1 = 2'b11
  } line_t;

  typedef enum logic [1:0] {
    SPD_LS  = 2'b00,
    SPD_FS  = 2'b01,
    SPD_HS  = 2'b10,
    SPD_RSV = 2'b11
  } speed_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_L1_ENTER,
    ST_L1,
    ST_RESUME_UP,
    ST_RESUME_DOWN,
    ST_RESUME_END
  } l1_state_t;

  function automatic logic bus_is_idle(input speed_t spd, input line_t ln);
    if (spd == SPD_HS) return ln == LINE_SE0;
    return ln == LINE_J;
  endfunction

  function automatic logic in_resume(input l1_state_t st);
    return (st == ST_RESUME_UP) || (st == ST_RESUME_DOWN);
  endfunction

endpackage

// File: rtl/l1_cycle_timer.sv
module l1_cycle_timer #(
  parameter int LIMIT = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic done
);
  localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;

  logic [CW-1:0] cnt_q;

  assign done = run && (cnt_q == CW'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (rst || !run) cnt_q <= '0;
    else if (!done)  cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/l1_k_repeater.sv
module l1_k_repeater (
  input  logic clk,
  input  logic rst,
  input  logic toward_dn_en,
  input  logic toward_up_en,
  input  logic up_is_k,
  input  logic dn_is_k,
  output logic rep_to_dn,
  output logic rep_to_up
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rep_to_dn <= 1'b0;
      rep_to_up <= 1'b0;
    end else begin
      rep_to_dn <= toward_dn_en && up_is_k;
      rep_to_up <= toward_up_en && dn_is_k;
    end
  end
endmodule

// File: rtl/l1_sleep_ctrl.sv
module l1_sleep_ctrl
  import l1_pkg::*;
#(
  parameter int ENTER_CYCLES    = 64,
  parameter int DEADLINE_CYCLES = 6250,
  parameter int SE0_CYCLES      = 167
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] up_line,
  input  logic [1:0] dn_line,
  input  logic [1:0] speed_in,
  input  logic       l1_req,
  output logic       low_power,
  output logic       hs_enable,
  output logic       rep_k_to_up,
  output logic       rep_k_to_dn,
  output logic       idle_valid,
  output logic [1:0] idle_speed
);
  line_t     up_ln, dn_ln;
  speed_t    spd_now, saved_q;
  l1_state_t state_q, state_d;
  logic      host_k_q;
  logic      enter_done, se0_done, se0_run;
  logic      saved_hs;

  assign up_ln    = line_t'(up_line);
  assign dn_ln    = line_t'(dn_line);
  assign spd_now  = speed_t'(speed_in);
  assign saved_hs = (saved_q == SPD_HS);

  l1_cycle_timer #(.LIMIT(ENTER_CYCLES)) u_enter_tmr (
    .clk  (clk),
    .rst  (rst),
    .run  (state_q == ST_L1_ENTER),
    .done (enter_done)
  );

  assign se0_run = in_resume(state_q) && host_k_q && !saved_hs && (up_ln == LINE_SE0);

  l1_cycle_timer #(.LIMIT(SE0_CYCLES)) u_se0_tmr (
    .clk  (clk),
    .rst  (rst),
    .run  (se0_run),
    .done (se0_done)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:
        if (l1_req && bus_is_idle(spd_now, up_ln)) state_d = ST_L1_ENTER;
      ST_L1_ENTER:
        if (enter_done) state_d = ST_L1;
      ST_L1:
        if (up_ln == LINE_K)      state_d = ST_RESUME_UP;
        else if (dn_ln == LINE_K) state_d = ST_RESUME_DOWN;
      ST_RESUME_UP, ST_RESUME_DOWN:
        if (saved_hs) begin
          if (host_k_q && up_ln == LINE_SE0) state_d = ST_RESUME_END;
        end else if (se0_done) begin
          state_d = ST_RESUME_END;
        end
      ST_RESUME_END:
        if (saved_hs || up_ln == LINE_J) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      saved_q    <= spd_now;
      host_k_q   <= 1'b0;
      low_power  <= 1'b0;
      idle_valid <= 1'b1;
      hs_enable  <= (spd_now == SPD_HS);
      idle_speed <= speed_in;
    end else begin
      state_q  <= state_d;
      host_k_q <= in_resume(state_d) && (host_k_q || up_ln == LINE_K);
      if (state_q == ST_IDLE) saved_q <= spd_now;
      low_power  <= (state_d != ST_IDLE) && (state_d != ST_L1_ENTER);
      idle_valid <= (state_d == ST_IDLE);
      if (state_d != ST_IDLE)       hs_enable <= 1'b0;
      else if (state_q == ST_IDLE)  hs_enable <= (spd_now == SPD_HS);
      else                          hs_enable <= saved_hs;
      idle_speed <= (state_q == ST_IDLE) ? speed_in : saved_q;
    end
  end

  l1_k_repeater u_rep (
    .clk          (clk),
    .rst          (rst),
    .toward_dn_en (state_d == ST_RESUME_UP),
    .toward_up_en (state_d == ST_RESUME_DOWN),
    .up_is_k      (up_ln == LINE_K),
    .dn_is_k      (dn_ln == LINE_K),
    .rep_to_dn    (rep_k_to_dn),
    .rep_to_up    (rep_k_to_up)
  );
endmodule

// File: rtl/l1_sleep_ctrl_chk.sv
module l1_sleep_ctrl_chk #(
  parameter int DEADLINE_CYCLES = 6250
) (
  input logic       clk,
  input logic       rst,
  input logic [1:0] up_line,
  input logic [1:0] dn_line,
  input logic [1:0] speed_in,
  input logic       l1_req,
  input logic       low_power,
  input logic       hs_enable,
  input logic       rep_k_to_up,
  input logic       rep_k_to_dn,
  input logic       idle_valid,
  input logic [1:0] idle_speed
);
  localparam int DW = $clog2(DEADLINE_CYCLES + 2);
  logic [DW-1:0] entering_cnt;
  logic          bus_ok;

  assign bus_ok = (speed_in == 2'b10) ? (up_line == 2'b00) : (up_line == 2'b01);

  always_ff @(posedge clk) begin
    if (rst || idle_valid || low_power) entering_cnt <= '0;
    else if (entering_cnt != '1)        entering_cnt <= entering_cnt + 1'b1;
  end

  AST_ENTRY_DEADLINE: assert property (@(posedge clk) disable iff (rst)
    entering_cnt <= DW'(DEADLINE_CYCLES)); // R3
  AST_IGNORE_BUSY_REQ: assert property (@(posedge clk) disable iff (rst)
    (idle_valid && l1_req && !bus_ok) |=> idle_valid); // R2
  AST_HS_OFF_ASLEEP: assert property (@(posedge clk) disable iff (rst)
    low_power |-> !hs_enable); // R4
  AST_ASLEEP_NOT_IDLE: assert property (@(posedge clk) disable iff (rst)
    low_power |-> !idle_valid); // R5
  AST_REP_DN_FROM_K: assert property (@(posedge clk) disable iff (rst)
    rep_k_to_dn |-> ($past(up_line) == 2'b10)); // R6
  AST_REP_UP_FROM_K: assert property (@(posedge clk) disable iff (rst)
    rep_k_to_up |-> ($past(dn_line) == 2'b10)); // R7
  AST_REP_ONE_WAY: assert property (@(posedge clk) disable iff (rst)
    !(rep_k_to_up && rep_k_to_dn)); // R7
  AST_WAKE_LEAVES_LP: assert property (@(posedge clk) disable iff (rst)
    $rose(idle_valid) |-> !low_power); // R8
  AST_NO_REP_IN_IDLE: assert property (@(posedge clk) disable iff (rst)
    idle_valid |-> !(rep_k_to_up || rep_k_to_dn)); // R1
endmodule

bind l1_sleep_ctrl l1_sleep_ctrl_chk #(.DEADLINE_CYCLES(DEADLINE_CYCLES)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .up_line     (up_line),
  .dn_line     (dn_line),
  .speed_in    (speed_in),
  .l1_req      (l1_req),
  .low_power   (low_power),
  .hs_enable   (hs_enable),
  .rep_k_to_up (rep_k_to_up),
  .rep_k_to_dn (rep_k_to_dn),
  .idle_valid  (idle_valid),
  .idle_speed  (idle_speed)
);

// File: tb/test_l1_sleep_ctrl.sv
module test_l1_sleep_ctrl;
  localparam int ENTER = 5;
  localparam int DEAD  = 8;
  localparam int SE0N  = 4;
  localparam logic [1:0] SE0 = 2'b00, J = 2'b01, K = 2'b10;
  localparam logic [1:0] LS = 2'b00, FS = 2'b01, HS = 2'b10;

  logic clk = 1'b0, rst = 1'b1;
  logic [1:0] up_line = J, dn_line = J, speed_in = LS;
  logic l1_req = 1'b0;
  logic low_power, hs_enable, rep_k_to_up, rep_k_to_dn, idle_valid;
  logic [1:0] idle_speed;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  l1_sleep_ctrl #(.ENTER_CYCLES(ENTER), .DEADLINE_CYCLES(DEAD), .SE0_CYCLES(SE0N)) i_l1_sleep_ctrl (
    .clk(clk), .rst(rst), .up_line(up_line), .dn_line(dn_line), .speed_in(speed_in),
    .l1_req(l1_req), .low_power(low_power), .hs_enable(hs_enable),
    .rep_k_to_up(rep_k_to_up), .rep_k_to_dn(rep_k_to_dn),
    .idle_valid(idle_valid), .idle_speed(idle_speed)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  task automatic enter(input logic [1:0] s);
    speed_in = s;
    up_line  = (s == HS) ? SE0 : J;
    dn_line  = up_line;
    tick(1);
    l1_req = 1'b1;
    tick(1);
    l1_req = 1'b0;
    chk("R3 idle_valid drops on accept", idle_valid, 0);
    chk("R4 hs_enable low from accept", hs_enable, 0);
    tick(ENTER - 1);
    chk("R3 low_power not yet", low_power, 0);
    tick(1);
    chk("R3 low_power at ENTER edges", low_power, 1);
    chk("R5 idle_valid low asleep", idle_valid, 0);
    chk("R5 hs_enable low asleep", hs_enable, 0);
  endtask

  task automatic finish_resume(input logic [1:0] s);
    dn_line = (s == HS) ? SE0 : J;
    up_line = SE0;
    if (s == HS) begin
      tick(1);
      chk("R10 resume end not idle yet", idle_valid, 0);
      chk("R10 hs_enable still off", hs_enable, 0);
      tick(1);
      chk("R10 idle after HS resume", idle_valid, 1);
      chk("R10 hs_enable restored", hs_enable, 1);
    end else begin
      tick(SE0N);
      chk("R8 waiting for J after SE0", idle_valid, 0);
      chk("R8 still low power before J", low_power, 1);
      up_line = J;
      tick(1);
      chk("R8 idle after J", idle_valid, 1);
      chk("R8 low_power off after J", low_power, 0);
      chk("R5 hs_enable stays off", hs_enable, 0);
    end
    chk("R11 restored speed", idle_speed, s);
    chk("R1 no repeat in idle", rep_k_to_up | rep_k_to_dn, 0);
  endtask

  task automatic wake_up(input logic [1:0] s, input int glitch);
    up_line = K;
    tick(1);
    chk("R6 K repeated downstream", rep_k_to_dn, 1);
    chk("R6 no upstream repeat", rep_k_to_up, 0);
    dn_line = K;
    tick(1);
    chk("R6 echo not looped back", rep_k_to_up, 0);
    chk("R6 repeat continues", rep_k_to_dn, 1);
    dn_line = (s == HS) ? SE0 : J;
    if (glitch > 0) begin
      up_line = SE0;
      tick(glitch);
      up_line = K;
      tick(1);
      chk("R9 short SE0 ignored", low_power, 1);
      chk("R9 still not idle", idle_valid, 0);
      chk("R9 K repetition resumes", rep_k_to_dn, 1);
    end
  endtask

  task automatic wake_dn(input logic [1:0] s);
    dn_line = K;
    tick(1);
    chk("R7 K repeated upstream", rep_k_to_up, 1);
    chk("R7 no downstream repeat", rep_k_to_dn, 0);
    if (s == HS) begin
      tick(2);
      chk("R10 no exit before host K", low_power, 1);
    end
    up_line = K;
    tick(1);
    chk("R7 host K not repeated down", rep_k_to_dn, 0);
    chk("R7 device K still repeated", rep_k_to_up, 1);
    dn_line = (s == HS) ? SE0 : J;
    tick(1);
    chk("R7 repeat stops with device K", rep_k_to_up, 0);
  endtask

  initial begin
    #(8 * 100000);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog: actual hung expected finish");
    report();
  end

  initial begin
    tick(2);
    chk("R1 reset idle_valid", idle_valid, 1);
    chk("R1 reset low_power", low_power, 0);
    chk("R1 reset hs_enable", hs_enable, 0);
    chk("R1 reset repeats", rep_k_to_up | rep_k_to_dn, 0);
    chk("R1 reset idle_speed", idle_speed, LS);
    rst = 1'b0;
    speed_in = HS;
    tick(1);
    chk("R1 hs_enable tracks speed", hs_enable, 1);
    chk("R1 idle_speed tracks speed", idle_speed, HS);

    // R2: requests on a busy bus
    speed_in = LS; up_line = K; l1_req = 1'b1; tick(1); l1_req = 1'b0;
    tick(ENTER + 2);
    chk("R2 LS K-bus request ignored", idle_valid, 1);
    chk("R2 LS no low power", low_power, 0);
    speed_in = HS; up_line = J; l1_req = 1'b1; tick(1); l1_req = 1'b0;
    tick(ENTER + 2);
    chk("R2 HS J-bus request ignored", idle_valid, 1);
    chk("R2 HS hs_enable kept", hs_enable, 1);

    for (int sp = 0; sp < 2; sp++) begin
      for (int g = 0; g < SE0N; g++) begin
        enter(2'(sp));
        wake_up(2'(sp), g);
        finish_resume(2'(sp));
      end
    end
    for (int sp = 0; sp < 3; sp++) begin
      enter(2'(sp));
      wake_dn(2'(sp));
      finish_resume(2'(sp));
    end
    enter(HS);
    wake_up(HS, 0);
    finish_resume(HS);

    // R7: both ports show K in the same cycle
    enter(FS);
    up_line = K; dn_line = K;
    tick(1);
    chk("R7 tie goes upstream: rep_k_to_dn", rep_k_to_dn, 1);
    chk("R7 tie goes upstream: rep_k_to_up", rep_k_to_up, 0);
    finish_resume(FS);

    report();
  end
endmodule